// File: doc/BRIEF.md
# Parallel-bus LCD window writer

This block feeds a colour TFT panel controller through a 16-bit parallel write bus of the 8080 kind, with separate chip-select, register-select, write and read strobes. A host processor places a rectangle on the inputs and pulses `start`. The writer then programs the panel's update window with four command/parameter pairs, issues a memory-write command, and streams exactly the number of 16-bit colour pixels that the rectangle holds. It takes these pixels from a frame-buffer read port through a valid/ready handshake.

The panel is 480 by 272 pixels. A rectangle that leaves the panel, or whose start lies past its end on either axis, is refused. The block raises a one-cycle error pulse and leaves the bus untouched. If the pixel source runs dry mid-stream, the bus pauses with the write strobe high and chip-select still asserted. After the last pixel has been written, `busy` falls and `done` pulses.

Top module: `lcd_window_writer`

## Requirements
- R1: During and straight after reset, `lcd_cs_n`, `lcd_wr_n` and `lcd_rd_n` are 1, and `busy`, `done`, `err` and `pix_ready` are 0.
- R2: A `start` taken while idle with `x_end` > 479, `y_end` > 271, `x_start` > `x_end` or `y_start` > `y_end` makes `err` 1 for exactly the next cycle. `busy` stays 0, `lcd_cs_n` stays 1 and no write strobe occurs.
- R3: A valid `start` produces nine bus writes in the following order, with RS (`lcd_rs`) 0 for a command and 1 for a parameter: command 0x0050, then `x_start`; command 0x0051, then `x_end`; command 0x0052, then `y_start`; command 0x0053, then `y_end`; then command 0x0022. Parameters are zero-extended to 16 bits.
- R4: After the 0x0022 command, exactly (x_end-x_start+1)*(y_end-y_start+1) writes with RS=1 follow. They carry the pixels in the order the handshake accepted them (a pixel is taken on a clock edge where `pix_valid` and `pix_ready` are both 1), and no further write follows.
- R5: Each write holds `lcd_wr_n` low for exactly WR_LO clock cycles (1 by default). `lcd_db` and `lcd_rs` do not change on the edge where `lcd_wr_n` rises, which latches the word. `lcd_rd_n` is always 1.
- R6: When `pix_ready` is 1 and `pix_valid` is 0, no write begins on that edge: `lcd_wr_n` stays 1 and `lcd_cs_n` stays 0.
- R7: `lcd_cs_n` goes low in the cycle after a valid `start` is accepted and stays low through every write of the window. `busy` goes high at the same time. `done` is a one-cycle pulse raised on the edge where `busy` falls and `lcd_cs_n` returns high, after the last write has completed.
- R8: A `start` pulse while `busy` is 1 is ignored: no error is raised and the running write sequence is unchanged.
- R9: A one-pixel window at the far corner (x 479..479, y 271..271) is accepted and writes exactly one pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a window transfer (sampled while idle) |
| x_start | input | 9 | First column of the window |
| x_end | input | 9 | Last column of the window |
| y_start | input | 9 | First row of the window |
| y_end | input | 9 | Last row of the window |
| pix_data | input | 16 | Pixel colour from the frame-buffer port |
| pix_valid | input | 1 | Pixel source has a word available |
| pix_ready | output | 1 | Writer takes the pixel on this edge if valid |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_rs | output | 1 | 0 = command word, 1 = parameter or pixel |
| lcd_wr_n | output | 1 | Write strobe, data latched on its rising edge |
| lcd_rd_n | output | 1 | Read strobe, held inactive |
| lcd_db | output | 16 | Parallel data bus |
| busy | output | 1 | Window transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| err | output | 1 | One-cycle pulse for a refused window |

## Verification
A wrong setup index shows up on the first write strobe after `start`, as a command or parameter that is out of order or carries the wrong RS level. A miscounted pixel counter shows up at the end of the window, where `done` arrives one write early or one write late against the queue of expected words. A pixel handshake that takes a word twice or drops one makes the next written pixel differ from the expected value within one write cycle. A broken stall path raises `lcd_wr_n` activity on a cycle where the source offered nothing, which is caught on the following edge.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;

    localparam int unsigned BUS_W       = 16;
    localparam int unsigned SETUP_WORDS = 9;

    typedef logic [BUS_W-1:0] word_t;

    typedef struct packed {
        logic  rs;
        word_t data;
    } bus_item_t;

    localparam word_t CMD_COL_LO = 16'h0050;
    localparam word_t CMD_COL_HI = 16'h0051;
    localparam word_t CMD_ROW_LO = 16'h0052;
    localparam word_t CMD_ROW_HI = 16'h0053;
    localparam word_t CMD_GRAM   = 16'h0022;

    typedef enum logic [1:0] {SQ_IDLE, SQ_SETUP, SQ_PIXELS} seq_state_t;
    typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH}     phy_state_t;

    // Word for step idx of the window-programming sequence.
    function automatic bus_item_t setup_item(input logic [3:0] idx,
                                             input word_t c0, input word_t c1,
                                             input word_t r0, input word_t r1);
        bus_item_t it;
        case (idx)
            4'd0:    it = '{rs: 1'b0, data: CMD_COL_LO};
            4'd1:    it = '{rs: 1'b1, data: c0};
            4'd2:    it = '{rs: 1'b0, data: CMD_COL_HI};
            4'd3:    it = '{rs: 1'b1, data: c1};
            4'd4:    it = '{rs: 1'b0, data: CMD_ROW_LO};
            4'd5:    it = '{rs: 1'b1, data: r0};
            4'd6:    it = '{rs: 1'b0, data: CMD_ROW_HI};
            4'd7:    it = '{rs: 1'b1, data: r1};
            default: it = '{rs: 1'b0, data: CMD_GRAM};
        endcase
        return it;
    endfunction

endpackage

// File: rtl/lcdw_win_check.sv
module lcdw_win_check #(
    parameter int unsigned H_RES = 480,
    parameter int unsigned V_RES = 272,
    parameter int unsigned XW    = 9,
    parameter int unsigned YW    = 9,
    parameter int unsigned CW    = 17
) (
    input  logic [XW-1:0] xs,
    input  logic [XW-1:0] xe,
    input  logic [YW-1:0] ys,
    input  logic [YW-1:0] ye,
    output logic          ok,
    output logic [CW-1:0] count
);
    localparam logic [XW-1:0] X_MAX = XW'(H_RES - 1);
    localparam logic [YW-1:0] Y_MAX = YW'(V_RES - 1);

    logic [XW:0] width;
    logic [YW:0] height;

    always_comb begin
        ok     = (xe <= X_MAX) && (ye <= Y_MAX) && (xs <= xe) && (ys <= ye);
        width  = {1'b0, xe} - {1'b0, xs} + 1'b1;
        height = {1'b0, ye} - {1'b0, ys} + 1'b1;
        count  = CW'(width) * CW'(height);
    end
endmodule

// File: rtl/lcdw_bus_phy.sv
module lcdw_bus_phy
    import lcdw_pkg::*;
#(
    parameter int unsigned WR_LO = 1,
    parameter int unsigned WR_HI = 1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      issue,
    input  bus_item_t item,
    output logic      ready,
    output logic      wr_n,
    output logic      rs,
    output word_t     db
);
    localparam int unsigned LONGEST = (WR_LO > WR_HI) ? WR_LO : WR_HI;
    localparam int unsigned TW      = $clog2(LONGEST + 1);

    phy_state_t    state;
    logic [TW-1:0] tmr;

    // A new word may start in the last high cycle of the previous one.
    assign ready = (state == PH_IDLE) || ((state == PH_HIGH) && (tmr == '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PH_IDLE;
            tmr   <= '0;
            wr_n  <= 1'b1;
            rs    <= 1'b0;
            db    <= '0;
        end else if (ready && issue) begin
            state <= PH_LOW;
            tmr   <= TW'(WR_LO - 1);
            wr_n  <= 1'b0;
            rs    <= item.rs;
            db    <= item.data;
        end else begin
            case (state)
                PH_LOW: begin
                    if (tmr == '0) begin
                        state <= PH_HIGH;
                        tmr   <= TW'(WR_HI - 1);
                        wr_n  <= 1'b1;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (tmr == '0) state <= PH_IDLE;
                    else           tmr   <= tmr - 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/lcdw_seq.sv
module lcdw_seq
    import lcdw_pkg::*;
#(
    parameter int unsigned CW = 17
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          win_ok,
    input  logic [CW-1:0] win_count,
    input  word_t         c0,
    input  word_t         c1,
    input  word_t         r0,
    input  word_t         r1,
    input  logic          pix_valid,
    input  word_t         pix_data,
    input  logic          phy_ready,
    output logic          issue,
    output bus_item_t     item,
    output logic          pix_ready,
    output logic          busy,
    output logic          done,
    output logic          err
);
    seq_state_t    state;
    logic [3:0]    step;
    logic [CW-1:0] left;
    word_t         c0_q, c1_q, r0_q, r1_q;

    assign busy      = (state != SQ_IDLE);
    assign pix_ready = (state == SQ_PIXELS) && phy_ready && (left != '0);

    always_comb begin
        issue = 1'b0;
        item  = '{rs: 1'b1, data: pix_data};
        case (state)
            SQ_SETUP: begin
                issue = phy_ready;
                item  = setup_item(step, c0_q, c1_q, r0_q, r1_q);
            end
            SQ_PIXELS: issue = pix_ready && pix_valid;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            step  <= '0;
            left  <= '0;
            c0_q  <= '0;
            c1_q  <= '0;
            r0_q  <= '0;
            r1_q  <= '0;
            done  <= 1'b0;
            err   <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        if (win_ok) begin
                            c0_q  <= c0;
                            c1_q  <= c1;
                            r0_q  <= r0;
                            r1_q  <= r1;
                            left  <= win_count;
                            step  <= '0;
                            state <= SQ_SETUP;
                        end else begin
                            err <= 1'b1;
                        end
                    end
                end
                SQ_SETUP: begin
                    if (issue) begin
                        step <= step + 1'b1;
                        if (step == 4'(SETUP_WORDS - 1)) state <= SQ_PIXELS;
                    end
                end
                SQ_PIXELS: begin
                    if (issue) begin
                        left <= left - 1'b1;
                    end else if ((left == '0) && phy_ready) begin
                        state <= SQ_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lcd_window_writer.sv
module lcd_window_writer
    import lcdw_pkg::*;
#(
    parameter int unsigned H_RES = 480,
    parameter int unsigned V_RES = 272,
    parameter int unsigned WR_LO = 1,
    parameter int unsigned WR_HI = 1,
    parameter int unsigned XW    = $clog2(H_RES),
    parameter int unsigned YW    = $clog2(V_RES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [XW-1:0] x_start,
    input  logic [XW-1:0] x_end,
    input  logic [YW-1:0] y_start,
    input  logic [YW-1:0] y_end,
    input  logic [15:0]   pix_data,
    input  logic          pix_valid,
    output logic          pix_ready,
    output logic          lcd_cs_n,
    output logic          lcd_rs,
    output logic          lcd_wr_n,
    output logic          lcd_rd_n,
    output logic [15:0]   lcd_db,
    output logic          busy,
    output logic          done,
    output logic          err
);
    localparam int unsigned CW = $clog2(H_RES * V_RES + 1);

    logic          win_ok;
    logic [CW-1:0] win_count;
    logic          phy_ready;
    logic          issue;
    bus_item_t     item;

    lcdw_win_check #(
        .H_RES(H_RES), .V_RES(V_RES), .XW(XW), .YW(YW), .CW(CW)
    ) u_check (
        .xs(x_start), .xe(x_end), .ys(y_start), .ye(y_end),
        .ok(win_ok), .count(win_count)
    );

    lcdw_seq #(.CW(CW)) u_seq (
        .clk(clk), .rst(rst), .start(start),
        .win_ok(win_ok), .win_count(win_count),
        .c0(word_t'(x_start)), .c1(word_t'(x_end)),
        .r0(word_t'(y_start)), .r1(word_t'(y_end)),
        .pix_valid(pix_valid), .pix_data(pix_data),
        .phy_ready(phy_ready), .issue(issue), .item(item),
        .pix_ready(pix_ready), .busy(busy), .done(done), .err(err)
    );

    lcdw_bus_phy #(.WR_LO(WR_LO), .WR_HI(WR_HI)) u_phy (
        .clk(clk), .rst(rst), .issue(issue), .item(item),
        .ready(phy_ready), .wr_n(lcd_wr_n), .rs(lcd_rs), .db(lcd_db)
    );

    assign lcd_cs_n = ~busy;
    assign lcd_rd_n = 1'b1;
endmodule

// File: rtl/lcdw_checker.sv
module lcdw_checker (
    input logic        clk,
    input logic        rst,
    input logic        pix_ready,
    input logic        lcd_cs_n,
    input logic        lcd_rs,
    input logic        lcd_wr_n,
    input logic        lcd_rd_n,
    input logic [15:0] lcd_db,
    input logic        busy,
    input logic        done,
    input logic        err
);
    a_r5_read_idle: assert property (@(posedge clk) disable iff (rst)
        lcd_rd_n);

    a_r7_write_inside_cs: assert property (@(posedge clk) disable iff (rst)
        !lcd_wr_n |-> !lcd_cs_n);

    a_r5_hold_at_latch: assert property (@(posedge clk) disable iff (rst)
        $rose(lcd_wr_n) |-> ($stable(lcd_db) && $stable(lcd_rs)));

    a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy) && lcd_cs_n));

    a_r2_error_quiet: assert property (@(posedge clk) disable iff (rst)
        err |-> (!busy && lcd_cs_n && lcd_wr_n && !done));

    a_r6_ready_while_selected: assert property (@(posedge clk) disable iff (rst)
        pix_ready |-> (busy && !lcd_cs_n));
endmodule

bind lcd_window_writer lcdw_checker u_lcdw_checker (
    .clk(clk), .rst(rst), .pix_ready(pix_ready), .lcd_cs_n(lcd_cs_n),
    .lcd_rs(lcd_rs), .lcd_wr_n(lcd_wr_n), .lcd_rd_n(lcd_rd_n),
    .lcd_db(lcd_db), .busy(busy), .done(done), .err(err)
);

// File: tb/lcd_window_writer_tb.sv
module lcd_window_writer_tb_top;

    localparam int HALF = 10;
    localparam int WD_LIMIT = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [8:0]  x_start = '0, x_end = '0, y_start = '0, y_end = '0;
    logic [15:0] pix_data = '0;
    logic        pix_valid = 1'b0;
    logic        pix_ready, lcd_cs_n, lcd_rs, lcd_wr_n, lcd_rd_n, busy, done, err;
    logic [15:0] lcd_db;

    lcd_window_writer dut_i (
        .clk(clk), .rst(rst), .start(start),
        .x_start(x_start), .x_end(x_end), .y_start(y_start), .y_end(y_end),
        .pix_data(pix_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
        .lcd_cs_n(lcd_cs_n), .lcd_rs(lcd_rs), .lcd_wr_n(lcd_wr_n),
        .lcd_rd_n(lcd_rd_n), .lcd_db(lcd_db),
        .busy(busy), .done(done), .err(err)
    );

    always #HALF clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int writes = 0;
    int low_cnt = 0;

    logic [16:0] exp_q[$];

    // source state
    bit src_en = 0, src_stall = 0;
    int src_seed = 0, src_k = 0;
    bit hs = 0, stall_obs = 0;

    function automatic logic [15:0] pixval(int seed, int k);
        return 16'((seed * 257 + k * 4951) ^ 23130);
    endfunction

    task automatic check(input bit cond, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
            finish_run();
        end
    end

    // pixel source driver and stall observer (R6), WR low-time counter (R5)
    initial begin
        forever begin
            @(negedge clk);
            if (stall_obs)
                check(lcd_wr_n == 1'b1 && lcd_cs_n == 1'b0, "R6", "stall wr_n/cs_n",
                      {lcd_wr_n, lcd_cs_n}, 2'b10);
            if (!lcd_wr_n) low_cnt++;
            if (hs) src_k++;
            pix_valid = src_en && !(src_stall && (cyc % 3 != 0));
            pix_data  = pixval(src_seed, src_k);
            #2;
            stall_obs = pix_ready && !pix_valid;
            hs        = pix_valid && pix_ready;
        end
    end

    // scoreboard monitor: every rising WR edge latches one word
    always @(posedge lcd_wr_n) begin
        if (!rst) begin
            check(low_cnt == 1, "R5", "wr_n low cycles", low_cnt, 1);
            check(lcd_rd_n == 1'b1, "R5", "rd_n", lcd_rd_n, 1);
            check(lcd_cs_n == 1'b0, "R7", "cs_n during write", lcd_cs_n, 0);
            if (exp_q.size() == 0) begin
                check(1'b0, "R4", "unexpected write", {lcd_rs, lcd_db}, 0);
            end else begin
                logic [16:0] e;
                e = exp_q.pop_front();
                check({lcd_rs, lcd_db} == e, (writes < 9) ? "R3" : "R4",
                      "bus word {rs,db}", {lcd_rs, lcd_db}, e);
            end
            writes++;
        end
        low_cnt = 0;
    end

    task automatic pulse_start(int xs, int xe, int ys, int ye);
        @(negedge clk);
        x_start = 9'(xs); x_end = 9'(xe); y_start = 9'(ys); y_end = 9'(ye);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic bad_window(int xs, int xe, int ys, int ye);
        pulse_start(xs, xe, ys, ye);
        check(err == 1'b1, "R2", "err after bad start", err, 1);
        check(busy == 1'b0 && lcd_cs_n == 1'b1, "R2", "busy/cs_n on bad start",
              {busy, lcd_cs_n}, 2'b01);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(err == 1'b0 && lcd_cs_n == 1'b1 && lcd_wr_n == 1'b1 && busy == 1'b0,
                  "R2", "quiet after error", {err, lcd_cs_n, lcd_wr_n, busy}, 4'b0110);
        end
        check(writes == 0, "R2", "writes on bad window", writes, 0);
    endtask

    task automatic run_window(int xs, int xe, int ys, int ye, bit stall, int seed,
                              bit poke, string req);
        int n;
        bit seen;
        n = (xe - xs + 1) * (ye - ys + 1);
        exp_q.push_back({1'b0, 16'h0050}); exp_q.push_back({1'b1, 16'(xs)});
        exp_q.push_back({1'b0, 16'h0051}); exp_q.push_back({1'b1, 16'(xe)});
        exp_q.push_back({1'b0, 16'h0052}); exp_q.push_back({1'b1, 16'(ys)});
        exp_q.push_back({1'b0, 16'h0053}); exp_q.push_back({1'b1, 16'(ye)});
        exp_q.push_back({1'b0, 16'h0022});
        for (int k = 0; k < n; k++) exp_q.push_back({1'b1, pixval(seed, k)});
        writes = 0;
        src_seed = seed; src_stall = stall; src_k = 0; src_en = 1;
        pulse_start(xs, xe, ys, ye);
        check(busy == 1'b1 && lcd_cs_n == 1'b0, "R7", "busy/cs_n after start",
              {busy, lcd_cs_n}, 2'b10);
        if (poke) begin
            while (writes < 3) @(negedge clk);
            pulse_start(0, 500, 0, 0);
            check(err == 1'b0 && busy == 1'b1, "R8", "start while busy err/busy",
                  {err, busy}, 2'b01);
        end
        seen = 0;
        for (int i = 0; i < 20000 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        check(seen, "R7", "done pulse seen", seen, 1);
        check(busy == 1'b0 && lcd_cs_n == 1'b1 && pix_ready == 1'b0, "R7",
              "idle with done", {busy, lcd_cs_n, pix_ready}, 3'b010);
        @(negedge clk);
        check(done == 1'b0, "R7", "done one cycle", done, 0);
        check(exp_q.size() == 0, req, "words left in queue", exp_q.size(), 0);
        check(writes == 9 + n, req, "total writes", writes, 9 + n);
        src_en = 0;
        exp_q.delete();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(lcd_cs_n && lcd_wr_n && lcd_rd_n && !busy && !done && !err && !pix_ready,
              "R1", "outputs in reset",
              {lcd_cs_n, lcd_wr_n, lcd_rd_n, busy, done, err, pix_ready}, 7'b1110000);
        rst = 1'b0;
        @(negedge clk);
        check(lcd_cs_n && lcd_wr_n && lcd_rd_n && !busy && !done && !err && !pix_ready,
              "R1", "outputs after reset",
              {lcd_cs_n, lcd_wr_n, lcd_rd_n, busy, done, err, pix_ready}, 7'b1110000);

        bad_window(0, 480, 0, 10);
        bad_window(0, 10, 0, 272);
        bad_window(20, 19, 0, 10);
        bad_window(0, 10, 8, 7);

        run_window(479, 479, 271, 271, 1'b0, 3, 1'b0, "R9");
        run_window(0, 3, 0, 2, 1'b0, 11, 1'b0, "R4");
        run_window(10, 12, 5, 6, 1'b1, 29, 1'b1, "R8");
        run_window(100, 104, 200, 201, 1'b1, 47, 1'b0, "R6");

        finish_run();
    end
endmodule